// File: doc/BRIEF.md
# Commutation Delay and Timeout Timer

This block decides when a sensorless three-phase motor drive steps to its next winding state. A free-running interval counter measures the number of cycles between commutate strobes. The last sixteen measured intervals sit in a rolling window. When a zero-crossing event comes from the back-EMF filter, the block waits half the window's mean interval and then issues a commutate strobe. That wait is roughly thirty electrical degrees past the crossing. If no crossing comes before a programmable limit, the block forces the strobe by itself.

When the run request first goes high, the block steps the motor at a fixed slow rate. It keeps doing so until the first crossing is seen, and normal scheduling then takes over. Every strobe comes with a one-cycle pulse that clears the zero-crossing filter, so the filter can start a fresh search. A synced flag reports whether crossings keep arriving in time. Speed regulation and duty-cycle control belong to other blocks.

Top module: `cdt_commutation_timer`

## Requirements
- R1: While reset is held, and in the cycles after it until a strobe is due, `commutate_o`, `filt_clr_o` and `synced_o` are all low.
- R2: An accepted crossing in cycle z yields a strobe in cycle z+max(D,1)+1, where D = floor(S16/32). S16 is the sum of the sixteen most recent recorded intervals. Each strobe outside start-up records one interval: the cycle count since the previous strobe, saturated to 16 bits. The window starts filled with the start-up interval.
- R3: When no crossing is seen, a forced strobe follows the previous strobe by exactly max(L,2) cycles, where L is `timeout_lim_i`. A crossing in the last cycle before expiry is accepted, and the forced strobe is then dropped.
- R4: After the run request rises, strobes repeat every STARTUP_IVL cycles until the first crossing is accepted.
- R5: Each strobe lasts one cycle, and `filt_clr_o` is high in exactly the cycles where `commutate_o` is high.
- R6: `synced_o` goes high in the cycle after the sixth consecutive accepted crossing. It goes low in the strobe cycle of the sixth consecutive forced strobe. Crossings accepted during start-up count toward this run.
- R7: A crossing that arrives while a scheduled strobe is pending is ignored and does not move that strobe.
- R8: With the run request low, the block issues no strobe from the next cycle on, `synced_o` is low from the next cycle, and any pending strobe is cancelled. The window is refilled with the start-up interval, so the first scheduled delay after a restart is floor(STARTUP_IVL/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Run request; low keeps the block idle |
| zc_event_i | input | 1 | One-cycle pulse from the zero-crossing filter |
| timeout_lim_i | input | 16 | Forced-commutation limit in cycles since the last strobe |
| commutate_o | output | 1 | One-cycle strobe that advances the winding state |
| filt_clr_o | output | 1 | One-cycle clear pulse to the zero-crossing filter |
| synced_o | output | 1 | High while crossings are arriving in time |

## Verification
A zero crossing and timeout expiry can fall in the same cycle. This happens when the crossing lands on the last cycle before the forced strobe would fire. The bench provokes this by counting exactly L-1 quiet cycles after a strobe and then pulsing the crossing. It judges the result by the next strobe: it must arrive at the scheduled delay computed from the bench's own interval window, not one cycle after expiry. The synced count must also show an accepted crossing rather than a miss.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned CDT_IVL_W    = 16;
    localparam int unsigned CDT_AVG_LOG2 = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_DELAY
    } cdt_state_e;

    typedef enum logic [1:0] {
        FIRE_NONE,
        FIRE_STARTUP,
        FIRE_SCHED,
        FIRE_FORCED
    } fire_kind_e;

    typedef struct packed {
        cdt_state_e next;
        fire_kind_e fire;
        logic       accept_zc;
        logic       load_delay;
    } cdt_step_t;

    function automatic logic fire_is_strobe(fire_kind_e k);
        return k != FIRE_NONE;
    endfunction

    function automatic logic fire_records(fire_kind_e k);
        return (k == FIRE_SCHED) || (k == FIRE_FORCED);
    endfunction

endpackage

// File: rtl/cdt_ivl_counter.sv
module cdt_ivl_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_i,
    input  logic         restart_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= W'(1);
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/cdt_avg_window.sv
module cdt_avg_window #(
    parameter int unsigned W    = 16,
    parameter int unsigned LOG2 = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preload_i,
    input  logic [W-1:0] preload_val_i,
    input  logic         push_i,
    input  logic [W-1:0] push_val_i,
    output logic [W-1:0] half_mean_o
);
    localparam int unsigned DEPTH = 1 << LOG2;
    localparam int unsigned SUM_W = W + LOG2;

    logic [W-1:0]     slot_q [DEPTH];
    logic [LOG2-1:0]  wr_ptr_q;
    logic [SUM_W-1:0] sum_q;
    logic [W-1:0]     leaving;

    assign leaving = slot_q[wr_ptr_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || preload_i) begin
                slot_q[g] <= preload_val_i;
            end else if (push_i && (wr_ptr_q == LOG2'(g))) begin
                slot_q[g] <= push_val_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || preload_i) begin
            wr_ptr_q <= '0;
            sum_q    <= SUM_W'(preload_val_i) << LOG2;
        end else if (push_i) begin
            wr_ptr_q <= wr_ptr_q + LOG2'(1);
            sum_q    <= sum_q + SUM_W'(push_val_i) - SUM_W'(leaving);
        end
    end

    // mean / 2 == sum >> (LOG2 + 1)
    assign half_mean_o = {1'b0, sum_q[SUM_W-1:LOG2+1]};
endmodule

// File: rtl/cdt_sync_track.sv
module cdt_sync_track #(
    parameter int unsigned HIT_RUN  = 6,
    parameter int unsigned MISS_RUN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic hit_i,
    input  logic miss_i,
    output logic synced_o
);
    localparam int unsigned HW = $clog2(HIT_RUN + 1);
    localparam int unsigned MW = $clog2(MISS_RUN + 1);
    localparam logic [HW-1:0] HIT_LAST  = HW'(HIT_RUN - 1);
    localparam logic [HW-1:0] HIT_TOP   = HW'(HIT_RUN);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_RUN - 1);
    localparam logic [MW-1:0] MISS_TOP  = MW'(MISS_RUN);

    logic [HW-1:0] hits_q;
    logic [MW-1:0] misses_q;
    logic          synced_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            hits_q   <= '0;
            misses_q <= '0;
            synced_q <= 1'b0;
        end else if (hit_i) begin
            misses_q <= '0;
            if (hits_q != HIT_TOP) hits_q <= hits_q + HW'(1);
            if (hits_q == HIT_LAST) synced_q <= 1'b1;
        end else if (miss_i) begin
            hits_q <= '0;
            if (misses_q != MISS_TOP) misses_q <= misses_q + MW'(1);
            if (misses_q == MISS_LAST) synced_q <= 1'b0;
        end
    end

    assign synced_o = synced_q;
endmodule

// File: rtl/cdt_commutation_timer.sv
module cdt_commutation_timer
    import cdt_pkg::*;
#(
    parameter int unsigned IVL_W       = CDT_IVL_W,
    parameter int unsigned AVG_LOG2    = CDT_AVG_LOG2,
    parameter int unsigned STARTUP_IVL = 1000,
    parameter int unsigned SYNC_HITS   = 6,
    parameter int unsigned SYNC_MISSES = 6,
    parameter int unsigned MIN_TIMEOUT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en_i,
    input  logic             zc_event_i,
    input  logic [IVL_W-1:0] timeout_lim_i,
    output logic             commutate_o,
    output logic             filt_clr_o,
    output logic             synced_o
);
    localparam logic [IVL_W-1:0] START_LIM = IVL_W'(STARTUP_IVL);
    localparam logic [IVL_W-1:0] FLOOR_LIM = IVL_W'(MIN_TIMEOUT);

    cdt_state_e       state_q;
    cdt_step_t        step;
    logic [IVL_W-1:0] dly_q;
    logic [IVL_W-1:0] ivl_cnt;
    logic [IVL_W-1:0] half_mean;
    logic [IVL_W-1:0] eff_lim;
    logic             strobe_q;
    logic             clr_q;
    logic             idle_now;

    assign eff_lim  = (timeout_lim_i < FLOOR_LIM) ? FLOOR_LIM : timeout_lim_i;
    assign idle_now = (state_q == ST_IDLE);

    always_comb begin
        step.next       = state_q;
        step.fire       = FIRE_NONE;
        step.accept_zc  = 1'b0;
        step.load_delay = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step.next = ST_START;
            end
            ST_START: begin
                if (zc_event_i) begin
                    step.accept_zc  = 1'b1;
                    step.load_delay = 1'b1;
                    step.next       = ST_DELAY;
                end else if (ivl_cnt >= START_LIM) begin
                    step.fire = FIRE_STARTUP;
                end
            end
            ST_WAIT: begin
                if (zc_event_i) begin
                    step.accept_zc  = 1'b1;
                    step.load_delay = 1'b1;
                    step.next       = ST_DELAY;
                end else if (ivl_cnt >= eff_lim) begin
                    step.fire = FIRE_FORCED;
                end
            end
            ST_DELAY: begin
                if (dly_q <= IVL_W'(1)) begin
                    step.fire = FIRE_SCHED;
                    step.next = ST_WAIT;
                end
            end
            default: step.next = ST_IDLE;
        endcase
        if (!run_en_i) begin
            step.next       = ST_IDLE;
            step.fire       = FIRE_NONE;
            step.accept_zc  = 1'b0;
            step.load_delay = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            dly_q    <= '0;
            strobe_q <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            state_q  <= step.next;
            strobe_q <= fire_is_strobe(step.fire);
            clr_q    <= fire_is_strobe(step.fire);
            if (step.load_delay) begin
                dly_q <= half_mean;
            end else if (state_q == ST_DELAY && dly_q != '0) begin
                dly_q <= dly_q - IVL_W'(1);
            end
        end
    end

    cdt_ivl_counter #(
        .W(IVL_W)
    ) u_ivl (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (idle_now),
        .restart_i(fire_is_strobe(step.fire)),
        .count_o  (ivl_cnt)
    );

    cdt_avg_window #(
        .W   (IVL_W),
        .LOG2(AVG_LOG2)
    ) u_avg (
        .clk          (clk),
        .rst          (rst),
        .preload_i    (idle_now),
        .preload_val_i(START_LIM),
        .push_i       (fire_records(step.fire)),
        .push_val_i   (ivl_cnt),
        .half_mean_o  (half_mean)
    );

    cdt_sync_track #(
        .HIT_RUN (SYNC_HITS),
        .MISS_RUN(SYNC_MISSES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .clear_i (idle_now || !run_en_i),
        .hit_i   (step.accept_zc),
        .miss_i  (step.fire == FIRE_FORCED),
        .synced_o(synced_o)
    );

    assign commutate_o = strobe_q;
    assign filt_clr_o  = clr_q;
endmodule

// File: rtl/cdt_commutation_timer_chk.sv
module cdt_commutation_timer_chk (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic zc_event,
    input logic commutate,
    input logic filt_clr,
    input logic synced
);
    assert_clr_tracks_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        commutate == filt_clr);

    assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        commutate |=> !commutate);

    assert_idle_is_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!commutate && !synced));

    assert_sync_rise_after_zc_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> $past(zc_event));

    assert_sync_loss_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(synced) && $past(run_en)) |-> commutate);
endmodule

bind cdt_commutation_timer cdt_commutation_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en_i),
    .zc_event (zc_event_i),
    .commutate(commutate_o),
    .filt_clr (filt_clr_o),
    .synced   (synced_o)
);

// File: tb/tb_cdt_commutation_timer.sv
module tb_cdt_commutation_timer;
    localparam int CLK_PERIOD = 10;
    localparam int START_IVL  = 40;
    localparam int RUN_LEN    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        zc = 1'b0;
    logic [15:0] lim = 16'd300;
    logic        commutate, filt_clr, synced;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_strobe = 0;
    int ring [16];
    int rptr = 0;
    int hits = 0;
    int misses = 0;
    bit exp_synced = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdt_commutation_timer #(
        .STARTUP_IVL(START_IVL)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .run_en_i     (run_en),
        .zc_event_i   (zc),
        .timeout_lim_i(lim),
        .commutate_o  (commutate),
        .filt_clr_o   (filt_clr),
        .synced_o     (synced)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input bit z);
        zc = z;
        @(posedge clk);
        #1;
        cyc++;
        zc = 1'b0;
        if (commutate || filt_clr)
            check(commutate == filt_clr, "R5 clear pulse with strobe", int'(filt_clr), int'(commutate));
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            tick(1'b0);
            if (commutate) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic wait_strobe(input int maxc, output int t);
        t = -1;
        for (int i = 0; i < maxc; i++) begin
            tick(1'b0);
            if (commutate) begin
                t = cyc;
                break;
            end
        end
    endtask

    function automatic void model_preload();
        for (int i = 0; i < 16; i++) ring[i] = START_IVL;
        rptr = 0;
    endfunction

    function automatic void model_push(input int ivl);
        ring[rptr] = (ivl > 65535) ? 65535 : ivl;
        rptr = (rptr + 1) % 16;
    endfunction

    function automatic int sched_lat();
        int s = 0;
        int d;
        for (int i = 0; i < 16; i++) s += ring[i];
        d = s / 32;
        return ((d < 1) ? 1 : d) + 1;
    endfunction

    // accepted crossing after k quiet cycles; optional extra crossing while pending
    task automatic crossing_round(input int k, input bit extra, input string req);
        int z, lat, t;
        quiet(k, "R2 no strobe before crossing");
        z   = cyc;
        lat = sched_lat();
        tick(1'b1);
        hits++;
        misses = 0;
        if (hits >= RUN_LEN) exp_synced = 1'b1;
        check(synced == exp_synced, "R6 synced after crossing", int'(synced), int'(exp_synced));
        if (extra && lat >= 4) begin
            tick(1'b0);
            tick(1'b1);
        end
        wait_strobe(3000, t);
        check(t == z + lat, req, t - z, lat);
        model_push(t - last_strobe);
        last_strobe = t;
    endtask

    initial begin
        int t0, t1, t2, t;
        void'($urandom(32'd20240611));
        model_preload();

        repeat (3) tick(1'b0);
        check(commutate == 1'b0, "R1 strobe low in reset", int'(commutate), 0);
        check(filt_clr == 1'b0, "R1 clear low in reset", int'(filt_clr), 0);
        check(synced == 1'b0, "R1 synced low in reset", int'(synced), 0);
        rst = 1'b0;
        quiet(20, "R1 no strobe while not running");

        // start-up stepping at fixed rate
        run_en = 1'b1;
        wait_strobe(200, t0);
        wait_strobe(200, t1);
        wait_strobe(200, t2);
        check(t1 - t0 == START_IVL, "R4 start-up spacing", t1 - t0, START_IVL);
        check(t2 - t1 == START_IVL, "R4 start-up spacing", t2 - t1, START_IVL);
        last_strobe = t2;

        // first crossing leaves start-up with the preloaded half interval
        crossing_round(10, 1'b0, "R2 first delay from preloaded window");

        // random normal operation
        for (int r = 0; r < 30; r++) begin
            crossing_round($urandom_range(0, 150), (r % 5) == 2,
                           ((r % 5) == 2) ? "R7 extra crossing ignored" : "R2 scheduled delay");
        end

        // crossing in the final cycle before the timeout: crossing wins
        lim = 16'd100;
        crossing_round(99, 1'b0, "R3 crossing beats timeout in same cycle");

        // forced commutations
        lim = 16'd120;
        for (int i = 0; i < RUN_LEN; i++) begin
            wait_strobe(500, t);
            check(t - last_strobe == 120, "R3 forced interval", t - last_strobe, 120);
            model_push(t - last_strobe);
            last_strobe = t;
            hits = 0;
            misses++;
            if (misses >= RUN_LEN) exp_synced = 1'b0;
            check(synced == exp_synced, "R6 synced after forced strobe", int'(synced), int'(exp_synced));
        end

        // delay now reflects the forced intervals
        lim = 16'd300;
        crossing_round(30, 1'b0, "R2 delay after forced intervals");

        // limit below the floor
        lim = 16'd0;
        for (int i = 0; i < 3; i++) begin
            wait_strobe(50, t);
            check(t - last_strobe == 2, "R3 limit floor", t - last_strobe, 2);
            model_push(t - last_strobe);
            last_strobe = t;
        end
        lim = 16'd1;
        wait_strobe(50, t);
        check(t - last_strobe == 2, "R3 limit floor", t - last_strobe, 2);
        model_push(t - last_strobe);
        last_strobe = t;
        hits = 0;
        misses = RUN_LEN;
        exp_synced = 1'b0;

        // resynchronise, then drop the run request while a strobe is pending
        lim = 16'd300;
        for (int i = 0; i < RUN_LEN; i++) crossing_round(40, 1'b0, "R2 resync delay");
        check(synced == 1'b1, "R6 resynced", int'(synced), 1);
        quiet(5, "R2 no strobe before crossing");
        tick(1'b1);
        run_en = 1'b0;
        tick(1'b0);
        check(synced == 1'b0, "R8 synced cleared when stopped", int'(synced), 0);
        check(commutate == 1'b0, "R8 no strobe when stopped", int'(commutate), 0);
        quiet(400, "R8 pending strobe cancelled");

        // restart: window refilled with the start-up interval
        run_en = 1'b1;
        hits = 0;
        misses = 0;
        exp_synced = 1'b0;
        model_preload();
        wait_strobe(200, t);
        check(t > 0, "R4 start-up after restart", t, 1);
        last_strobe = t;
        crossing_round(5, 1'b0, "R8 delay after restart is half start-up interval");
        check(sched_lat() >= 2, "R2 model sanity", sched_lat(), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule